// File: doc/BRIEF.md
# Partial-Width Register File Writeback

This block is a general-purpose register file with two combinational read ports and one write port. A write does not always replace the whole register. The write port names a destination register and a destination width: the low byte, the second byte of the low half-word, 16 bits, 32 bits or the full 64 bits. It can also ask for the source value to be zero- or sign-extended from a narrower source width. The block merges the new bits into the current register contents. The rule for the upper bits depends on the width. Narrow writes of 8 and 16 bits keep every bit they do not cover. A 32-bit write always clears the upper half.

An execution pipeline drives the write port once per retired result and reads operands through the two read ports in the same cycle. If the combination of width, extension mode, source width and index is not meaningful, the block raises a flag in the same cycle and leaves the register file untouched. The pipeline can then turn that flag into a fault.

Top module: `narrow_write_regfile`

## Requirements
- R1: After reset every register reads back as zero on both read ports.
- R2: Both read ports are combinational. In the cycle of a write, a read of the destination returns the value held before the write, and the new value is visible from the cycle after the clock edge.
- R3: Width code 0 (low byte) replaces bits 7:0 with wr_data[7:0] and keeps bits 63:8.
- R4: Width code 1 (second byte) places wr_data[7:0] into bits 15:8 and keeps bits 7:0 and 63:16. It is legal only for register indices below HIBYTE_REGS (default 4); any other index is an illegal write.
- R5: Width code 2 (16 bits) replaces bits 15:0 and keeps bits 63:16.
- R6: Width code 3 (32 bits) writes bits 31:0 and forces bits 63:32 to zero.
- R7: Width code 4 (64 bits) with no extension replaces the whole register with wr_data.
- R8: Extension mode 1 (zero) takes the low 8, 16 or 32 bits of wr_data (source codes 0, 1, 2) and fills the bits above them with zeros up to the destination width. Example: byte 0xef extended to 64 bits gives 0x00000000000000ef.
- R9: Extension mode 2 (sign) fills the bits above the source width with copies of the source's top bit, up to the destination width. With a 16-bit destination, bits 63:16 are kept.
- R10: An extending write whose destination is 32 bits clears bits 63:32.
- R11: The write is illegal, and wr_illegal is 1 in the same cycle while wr_en is 1, in any of these cases: width code 5 to 7; extension mode 3; an extension with width code 0 or 1; an extension with source code 3 or with a source no narrower than the destination; the case noted in R4. An illegal write changes no register.
- R12: While wr_en is 0, no register changes and wr_illegal is 0, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Destination register index |
| wr_width | input | 3 | Destination width code (0 low byte, 1 second byte, 2 = 16, 3 = 32, 4 = 64 bits) |
| wr_ext | input | 2 | Extension mode (0 none, 1 zero, 2 sign) |
| wr_src | input | 2 | Source width for extension (0 = 8, 1 = 16, 2 = 32 bits) |
| wr_data | input | XLEN | Write data, right-aligned |
| wr_illegal | output | 1 | Write request is not a legal combination and is dropped |
| rd_idx0 | input | IDX_W | Read port 0 index |
| rd_data0 | output | XLEN | Read port 0 data |
| rd_idx1 | input | IDX_W | Read port 1 index |
| rd_data1 | output | XLEN | Read port 1 data |

## Verification
A read and a write can land on the same register in the same cycle. On every write, the bench points read port 0 at the destination and read port 1 at a different register. It samples both ports before the clock edge, where they must show the pre-write contents. It then reads the destination again after the edge and compares it with the merged value from the behavioural model. The legality decision and the merge also meet in one cycle. The bench therefore checks the illegal flag together with that post-edge readback, so a dropped write and a wrongly committed write are both seen.

// File: rtl/nwr_pkg.sv
package nwr_pkg;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned NUM_SRC  = 3;

   typedef enum logic [2:0] {
      WID_LO8 = 3'd0,
      WID_HI8 = 3'd1,
      WID_16  = 3'd2,
      WID_32  = 3'd3,
      WID_64  = 3'd4
   } wid_e;

   typedef enum logic [1:0] {
      EXT_KEEP = 2'd0,
      EXT_ZERO = 2'd1,
      EXT_SIGN = 2'd2
   } ext_e;

   typedef enum logic [1:0] {
      SRC_8  = 2'd0,
      SRC_16 = 2'd1,
      SRC_32 = 2'd2
   } srcw_e;

endpackage

// File: rtl/nwr_legal.sv
module nwr_legal
   import nwr_pkg::*;
#(
   parameter int unsigned NUM_REGS    = 16,
   parameter int unsigned HIBYTE_REGS = 4,
   parameter int unsigned IDX_W       = 4
)(
   input  logic [IDX_W-1:0] idx,
   input  logic [2:0]       wid,
   input  logic [1:0]       ext,
   input  logic [1:0]       src,
   output logic             ok
);

   logic idx_in_range;
   logic hib_in_range;
   logic wid_known;
   logic ext_known;
   logic hib_ok;
   logic ext_ok;
   logic src_narrower;

   assign idx_in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_REGS));
   assign hib_in_range = ({1'b0, idx} < (IDX_W+1)'(HIBYTE_REGS));
   assign wid_known    = (wid <= WID_64);
   assign ext_known    = (ext != 2'd3);
   assign hib_ok       = (wid != WID_HI8) || hib_in_range;

   // source rank 0/1/2 against destination rank wid-1 (16->1, 32->2, 64->3)
   assign src_narrower = (src != 2'd3) && (({1'b0, src} + 3'd2) <= wid);

   always_comb begin
      if (ext == EXT_KEEP) begin
         ext_ok = 1'b1;
      end else begin
         ext_ok = (wid >= WID_16) && src_narrower;
      end
   end

   assign ok = idx_in_range & wid_known & ext_known & hib_ok & ext_ok;

endmodule

// File: rtl/nwr_extend.sv
module nwr_extend
   import nwr_pkg::*;
#(
   parameter int unsigned XLEN = 64
)(
   input  logic [XLEN-1:0] din,
   input  logic [1:0]      ext,
   input  logic [1:0]      src,
   output logic [XLEN-1:0] dout
);

   logic [XLEN-1:0] lane_zero [4];
   logic [XLEN-1:0] lane_sign [4];
   logic [1:0]      sel;

   for (genvar g = 0; g < int'(NUM_SRC); g++) begin : g_lane
      localparam int unsigned SW = BYTE_W << g;
      assign lane_zero[g] = {{(XLEN-SW){1'b0}}, din[SW-1:0]};
      assign lane_sign[g] = {{(XLEN-SW){din[SW-1]}}, din[SW-1:0]};
   end

   assign lane_zero[3] = '0;
   assign lane_sign[3] = '0;

   assign sel = (src > SRC_32) ? SRC_32 : src;

   always_comb begin
      unique case (ext)
         EXT_ZERO: dout = lane_zero[sel];
         EXT_SIGN: dout = lane_sign[sel];
         default:  dout = din;
      endcase
   end

endmodule

// File: rtl/nwr_merge.sv
module nwr_merge
   import nwr_pkg::*;
#(
   parameter int unsigned XLEN = 64
)(
   input  logic [XLEN-1:0]   old_val,
   input  logic [XLEN-1:0]   ext_val,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [2:0]        wid,
   output logic [XLEN-1:0]   new_val
);

   localparam int unsigned HALF = XLEN / 2;

   always_comb begin
      unique case (wid)
         WID_LO8: new_val = {old_val[XLEN-1:BYTE_W], byte_in};
         WID_HI8: new_val = {old_val[XLEN-1:2*BYTE_W], byte_in, old_val[BYTE_W-1:0]};
         WID_16:  new_val = {old_val[XLEN-1:16], ext_val[15:0]};
         WID_32:  new_val = {{HALF{1'b0}}, ext_val[HALF-1:0]};
         default: new_val = ext_val;
      endcase
   end

endmodule

// File: rtl/narrow_write_regfile.sv
module narrow_write_regfile
   import nwr_pkg::*;
#(
   parameter int unsigned NUM_REGS    = 16,
   parameter int unsigned XLEN        = 64,
   parameter int unsigned HIBYTE_REGS = 4,
   parameter int unsigned IDX_W       = $clog2(NUM_REGS)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [2:0]       wr_width,
   input  logic [1:0]       wr_ext,
   input  logic [1:0]       wr_src,
   input  logic [XLEN-1:0]  wr_data,
   output logic             wr_illegal,
   input  logic [IDX_W-1:0] rd_idx0,
   output logic [XLEN-1:0]  rd_data0,
   input  logic [IDX_W-1:0] rd_idx1,
   output logic [XLEN-1:0]  rd_data1
);

   // elaboration-time parameter checks
   if (XLEN != 64) begin : g_bad_xlen
      $error("narrow_write_regfile: XLEN must be 64");
   end
   if (NUM_REGS < 2) begin : g_bad_regs
      $error("narrow_write_regfile: NUM_REGS must be at least 2");
   end
   if (HIBYTE_REGS > NUM_REGS) begin : g_bad_hib
      $error("narrow_write_regfile: HIBYTE_REGS exceeds NUM_REGS");
   end
   if ((1 << IDX_W) < NUM_REGS) begin : g_bad_idx
      $error("narrow_write_regfile: IDX_W too small for NUM_REGS");
   end

   logic [NUM_REGS-1:0][XLEN-1:0] regs_q;
   logic                          wr_ok;
   logic [XLEN-1:0]               ext_val;
   logic [XLEN-1:0]               old_val;
   logic [XLEN-1:0]               merged;

   function automatic logic [XLEN-1:0] pick(
      input logic [NUM_REGS-1:0][XLEN-1:0] arr,
      input logic [IDX_W-1:0]              i
   );
      if ({1'b0, i} < (IDX_W+1)'(NUM_REGS)) return arr[i];
      return '0;
   endfunction

   nwr_legal #(
      .NUM_REGS    (NUM_REGS),
      .HIBYTE_REGS (HIBYTE_REGS),
      .IDX_W       (IDX_W)
   ) i_legal (
      .idx (wr_idx),
      .wid (wr_width),
      .ext (wr_ext),
      .src (wr_src),
      .ok  (wr_ok)
   );

   nwr_extend #(.XLEN(XLEN)) i_extend (
      .din  (wr_data),
      .ext  (wr_ext),
      .src  (wr_src),
      .dout (ext_val)
   );

   assign old_val = pick(regs_q, wr_idx);

   nwr_merge #(.XLEN(XLEN)) i_merge (
      .old_val (old_val),
      .ext_val (ext_val),
      .byte_in (wr_data[BYTE_W-1:0]),
      .wid     (wr_width),
      .new_val (merged)
   );

   for (genvar r = 0; r < int'(NUM_REGS); r++) begin : g_reg
      logic            hit;
      logic [XLEN-1:0] q;

      assign hit = wr_en & wr_ok & (wr_idx == IDX_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (hit) begin
            q <= merged;
         end
      end

      assign regs_q[r] = q;
   end

   assign wr_illegal = wr_en & ~wr_ok;
   assign rd_data0   = pick(regs_q, rd_idx0);
   assign rd_data1   = pick(regs_q, rd_idx1);

endmodule

// File: rtl/nwr_checker.sv
module nwr_checker #(
   parameter int unsigned NUM_REGS    = 16,
   parameter int unsigned XLEN        = 64,
   parameter int unsigned HIBYTE_REGS = 4,
   parameter int unsigned IDX_W       = 4
)(
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic [IDX_W-1:0]              wr_idx,
   input logic [2:0]                    wr_width,
   input logic [1:0]                    wr_ext,
   input logic [1:0]                    wr_src,
   input logic [XLEN-1:0]               wr_data,
   input logic                          wr_illegal,
   input logic [NUM_REGS-1:0][XLEN-1:0] regs_q
);

   logic legal_wr;
   assign legal_wr = wr_en & ~wr_illegal;

   assert_lo8_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_wr && wr_width == 3'd0) |=>
         (regs_q[$past(wr_idx)][XLEN-1:8] == $past(regs_q[wr_idx][XLEN-1:8])) &&
         (regs_q[$past(wr_idx)][7:0] == $past(wr_data[7:0])));

   assert_hi8_places_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_wr && wr_width == 3'd1) |=>
         (regs_q[$past(wr_idx)][15:8] == $past(wr_data[7:0])) &&
         (regs_q[$past(wr_idx)][7:0] == $past(regs_q[wr_idx][7:0])) &&
         (regs_q[$past(wr_idx)][XLEN-1:16] == $past(regs_q[wr_idx][XLEN-1:16])));

   assert_hi8_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_width == 3'd1 && ({1'b0, wr_idx} >= (IDX_W+1)'(HIBYTE_REGS))) |-> wr_illegal);

   assert_w16_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_wr && wr_width == 3'd2) |=>
         (regs_q[$past(wr_idx)][XLEN-1:16] == $past(regs_q[wr_idx][XLEN-1:16])));

   assert_w32_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_wr && wr_width == 3'd3) |=> (regs_q[$past(wr_idx)][XLEN-1:32] == '0));

   assert_w64_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_wr && wr_width == 3'd4 && wr_ext == 2'd0) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

   assert_zext_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_wr && wr_width == 3'd4 && wr_ext == 2'd1 && wr_src == 2'd0) |=>
         (regs_q[$past(wr_idx)] == {{(XLEN-8){1'b0}}, $past(wr_data[7:0])}));

   assert_sext_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_wr && wr_width == 3'd4 && wr_ext == 2'd2 && wr_src == 2'd1) |=>
         (regs_q[$past(wr_idx)] == {{(XLEN-16){$past(wr_data[15])}}, $past(wr_data[15:0])}));

   assert_ext_w32_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_wr && wr_width == 3'd3 && wr_ext != 2'd0) |=> (regs_q[$past(wr_idx)][XLEN-1:32] == '0));

   assert_bad_ext_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ext != 2'd0 && wr_width <= 3'd1) |-> wr_illegal);

   assert_drop_illegal_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_illegal |=> (regs_q == $past(regs_q)));

   assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (regs_q == $past(regs_q)));

   assert_idle_noflag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> !wr_illegal);

endmodule

bind narrow_write_regfile nwr_checker #(
   .NUM_REGS    (NUM_REGS),
   .XLEN        (XLEN),
   .HIBYTE_REGS (HIBYTE_REGS),
   .IDX_W       (IDX_W)
) i_nwr_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .wr_width   (wr_width),
   .wr_ext     (wr_ext),
   .wr_src     (wr_src),
   .wr_data    (wr_data),
   .wr_illegal (wr_illegal),
   .regs_q     (regs_q)
);

// File: tb/test_narrow_write_regfile.sv
module test_narrow_write_regfile;

   localparam int CLK_PERIOD = 10;
   localparam int NREG = 16;
   localparam int HIB  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [2:0]  wr_width = '0;
   logic [1:0]  wr_ext = '0;
   logic [1:0]  wr_src = '0;
   logic [63:0] wr_data = '0;
   logic        wr_illegal;
   logic [3:0]  rd_idx0 = '0;
   logic [63:0] rd_data0;
   logic [3:0]  rd_idx1 = '0;
   logic [63:0] rd_data1;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic [63:0] mdl [NREG];

   always #(CLK_PERIOD/2) clk = ~clk;

   narrow_write_regfile i_narrow_write_regfile (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_width(wr_width), .wr_ext(wr_ext), .wr_src(wr_src), .wr_data(wr_data),
      .wr_illegal(wr_illegal), .rd_idx0(rd_idx0), .rd_data0(rd_data0),
      .rd_idx1(rd_idx1), .rd_data1(rd_data1)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic bit m_legal(int idx, int w, int e, int s);
      int sb, db;
      if (w > 4 || e == 3) return 0;
      if (w == 1 && idx >= HIB) return 0;
      if (e != 0) begin
         if (w < 2 || s == 3) return 0;
         sb = 8 << s;
         db = (w == 2) ? 16 : (w == 3) ? 32 : 64;
         if (sb >= db) return 0;
      end
      return 1;
   endfunction

   function automatic logic [63:0] m_value(logic [63:0] old, int w, int e, int s, logic [63:0] d);
      logic [63:0] v, mask;
      int sb;
      v = d;
      if (e != 0) begin
         sb = 8 << s;
         mask = (64'h1 << sb) - 64'h1;
         v = d & mask;
         if (e == 2 && d[sb-1]) v = v | ~mask;
      end
      case (w)
         0: return (old & ~64'hff) | (d & 64'hff);
         1: return (old & ~64'hff00) | ((d & 64'hff) << 8);
         2: return (old & ~64'hffff) | (v & 64'hffff);
         3: return v & 64'hffff_ffff;
         default: return v;
      endcase
   endfunction

   // one write cycle: same-cycle reads (R2), flag, then post-edge readback
   task automatic do_op(int idx, int w, int e, int s, logic [63:0] d, bit en, string tag);
      bit lg;
      int other;
      other = (idx + 5) % NREG;
      @(negedge clk);
      wr_en = en; wr_idx = 4'(idx); wr_width = 3'(w); wr_ext = 2'(e);
      wr_src = 2'(s); wr_data = d; rd_idx0 = 4'(idx); rd_idx1 = 4'(other);
      lg = m_legal(idx, w, e, s);
      #1;
      check("R2 same-cycle old value", rd_data0, mdl[idx]);
      check("R2 second port", rd_data1, mdl[other]);
      check({tag, " illegal flag"}, {63'b0, wr_illegal}, {63'b0, en && !lg});
      @(posedge clk);
      if (en && lg) mdl[idx] = m_value(mdl[idx], w, e, s, d);
      #1;
      wr_en = 1'b0;
      #1;
      check({tag, " readback"}, rd_data0, mdl[idx]);
   endtask

   task automatic peek(int idx, logic [63:0] exp, string tag);
      @(negedge clk);
      rd_idx1 = 4'(idx);
      #1;
      check(tag, rd_data1, exp);
   endtask

   function automatic string rtag(int idx, int w, int e, int s);
      if (!m_legal(idx, w, e, s)) return "R11 random";
      if (e == 1) return "R8 random";
      if (e == 2) return "R9 random";
      case (w)
         0: return "R3 random";
         1: return "R4 random";
         2: return "R5 random";
         3: return "R6 random";
         default: return "R7 random";
      endcase
   endfunction

   initial begin
      for (int i = 0; i < NREG; i++) mdl[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int i = 0; i < NREG; i++) peek(i, 64'h0, "R1 reset value");

      do_op(2, 4, 0, 0, 64'hffff_ffff_1234_5678, 1, "R7 full write");
      do_op(2, 0, 0, 0, 64'h1111_1111_1111_11aa, 1, "R3 low byte");
      peek(2, 64'hffff_ffff_1234_56aa, "R3 low byte literal");
      do_op(2, 1, 0, 0, 64'h0000_0000_0000_0055, 1, "R4 second byte");
      peek(2, 64'hffff_ffff_1234_55aa, "R4 second byte literal");
      do_op(2, 2, 0, 0, 64'h0000_0000_0000_beef, 1, "R5 half write");
      do_op(2, 3, 0, 0, 64'hdead_beef_8000_0001, 1, "R6 word write");
      peek(2, 64'h0000_0000_8000_0001, "R6 upper cleared literal");
      do_op(7, 4, 0, 0, 64'h0123_4567_89ab_cdef, 1, "R7 full write");
      do_op(7, 1, 0, 0, 64'h77, 1, "R4 index above alias range");
      do_op(5, 4, 0, 0, '1, 1, "R7 ones");
      do_op(5, 4, 1, 0, 64'hffff_ffff_ffff_ffef, 1, "R8 zext byte to 64");
      peek(5, 64'h0000_0000_0000_00ef, "R8 zext literal");
      do_op(6, 4, 0, 0, '1, 1, "R7 ones");
      do_op(6, 2, 1, 0, 64'h80, 1, "R8 zext byte to 16");
      do_op(6, 2, 2, 0, 64'h80, 1, "R9 sext byte to 16");
      peek(6, 64'hffff_ffff_ffff_ff80, "R9 sext 16 literal");
      do_op(7, 4, 2, 1, 64'h8001, 1, "R9 sext half to 64");
      do_op(8, 4, 0, 0, '1, 1, "R7 ones");
      do_op(8, 3, 2, 0, 64'h7f, 1, "R10 sext byte to 32");
      peek(8, 64'h0000_0000_0000_007f, "R10 literal");
      do_op(9, 4, 0, 0, '1, 1, "R7 ones");
      do_op(9, 3, 2, 1, 64'hc000, 1, "R10 sext half to 32");
      peek(9, 64'h0000_0000_ffff_c000, "R10 sext literal");
      do_op(9, 5, 0, 0, 64'h1, 1, "R11 width code 5");
      do_op(9, 4, 3, 0, 64'h1, 1, "R11 ext mode 3");
      do_op(9, 0, 1, 0, 64'h1, 1, "R11 ext to low byte");
      do_op(9, 3, 1, 2, 64'h1, 1, "R11 src not narrower");
      do_op(9, 4, 2, 3, 64'h1, 1, "R11 src code 3");
      peek(9, 64'h0000_0000_ffff_c000, "R11 register unchanged");
      do_op(9, 4, 0, 0, 64'h5555, 0, "R12 disabled write");
      do_op(9, 7, 3, 3, 64'h5555, 0, "R12 disabled bad combo");
      peek(9, 64'h0000_0000_ffff_c000, "R12 register unchanged");

      for (int k = 0; k < 400; k++) begin
         int idx, w, e, s;
         idx = int'($urandom_range(NREG-1, 0));
         w   = int'($urandom_range(7, 0));
         e   = int'($urandom_range(3, 0));
         s   = int'($urandom_range(3, 0));
         do_op(idx, w, e, s, {$urandom, $urandom}, ($urandom_range(7, 0) != 0), rtag(idx, w, e, s));
      end
      for (int i = 0; i < NREG; i++) peek(i, mdl[i], "R2 final readback");

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R2 watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule